// File: doc/BRIEF.md
# PHY Discovery and Configuration Sequencer

This block runs once per start pulse. It scans the management address space through an external MDIO master, decides which addresses answer as a PHY, and keeps a table of the addresses it finds. It uses only the master's request interface and does no bit-level MDIO timing itself. For every PHY it finds, it reads the control and advertisement registers. It rewrites the advertisement only when the wanted value differs from the value read. It then builds a new control value from the configured mode (autonegotiation, or forced speed and duplex) and writes it back only when it has changed.

The configuration inputs are captured on the start pulse and held for the whole scan. The MDIO master sees one request at a time. The sequencer holds `req_valid` and the request fields steady until the master pulses `mdio_done`. For a read, the master returns the data on `mdio_rdata` in that same cycle. Once the scan ends, the table, the count and `scan_done` stay valid until the next start pulse.

Top module: `phy_scan_seq`

## Requirements
- R1: Addresses are probed in the order 1, 2, …, 31 and then 0, each with a read of register 1 (status). Found addresses fill the table from slot 0 upward in discovery order. Slot k occupies `phy_table[5k+4:5k]`.
- R2: A status value S marks the address as present when `(S & 0x8301) == 0x8001`, or when bit 15 is clear and at least one of bits 14..11 is set. Any other status causes no further access to that address.
- R3: Once `MAX_PHYS` PHYs are recorded, probing stops at once and no higher-order address is accessed. `phy_count` never exceeds `MAX_PHYS`.
- R4: For a present PHY, register 0 is read and then register 4. If bits 8..5 of the advertisement read are all zero, the effective value is `{status[15:11]} << 5 | 1`. The wanted value is `cfg_adv` when that input is nonzero, and the effective value otherwise. Register 4 is written with the wanted value only when the two differ.
- R5: The new control value starts from the value read. In autonegotiation mode bit 12 is set, and bit 9 is also set if setting bit 12 changed the value. In forced mode bit 12 is cleared. Bits 15, 14, 13, 11, 10, 8 and 7 are then cleared. Bit 8 then takes `cfg_full_duplex` and bit 13 takes `cfg_speed100`.
- R6: Register 0 is written only when the new value differs from the value read. If bit 12 changed, the same value is written twice. Between the first write's `mdio_done` and the second request, `req_valid` is low for at least `PAUSE_CYCLES` cycles.
- R7: If the scan finds no PHY and `cfg_mii_expected` is 1, slot 0 holds address 1 and `phy_count` is 0. If `cfg_mii_expected` is 0, slot 0 stays 0.
- R8: While `req_valid` is high and `mdio_done` is low, the request fields stay unchanged in the next cycle. `req_valid` is low whenever `scan_done` is high.
- R9: After reset, and in the cycle after a start pulse, `scan_done`, `phy_count` and the table are zero. `scan_done` goes high when the scan ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that clears the results and begins a scan |
| cfg_autoneg | input | 1 | 1 = autonegotiation mode, 0 = forced mode |
| cfg_speed100 | input | 1 | Forced speed; drives control bit 13 |
| cfg_full_duplex | input | 1 | Forced duplex; drives control bit 8 |
| cfg_mii_expected | input | 1 | A PHY is expected; enables the address-1 fallback |
| cfg_adv | input | 16 | Configured advertisement; 0 = keep or derive |
| req_valid | output | 1 | MDIO request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | 5 | PHY address of the request |
| req_reg | output | 5 | Register number of the request |
| req_wdata | output | 16 | Write data |
| mdio_done | input | 1 | One-cycle completion pulse from the master |
| mdio_rdata | input | 16 | Read data, valid with `mdio_done` |
| phy_table | output | 5*MAX_PHYS | Found addresses, slot k at bits 5k+4..5k |
| phy_count | output | clog2(MAX_PHYS+1) | Number of PHYs found |
| scan_done | output | 1 | Scan finished; results valid |

## Verification
The bench compares the full ordered list of MDIO accesses against a list it builds itself. This catches errors in probe order, presence decisions, early stop, advertisement handling and control-write handling together. Directed scans cover the following cases:
- an empty bus, with and without a PHY expected;
- status values that sit on each side of both presence rules;
- a PHY at address 0, which must come last;
- more PHYs than table slots;
- autonegotiation being turned on, and turned off in forced mode, where the doubled write with its pause must appear.

Random scans with random status, control and advertisement contents then mix derived, configured and unchanged advertisement cases with writes that are skipped, single or doubled.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

    localparam logic [4:0]  REG_CTRL = 5'd0;
    localparam logic [4:0]  REG_STAT = 5'd1;
    localparam logic [4:0]  REG_ADV  = 5'd4;

    localparam int          CTL_AN_EN      = 12;
    localparam int          CTL_AN_RESTART = 9;
    localparam int          CTL_DUPLEX     = 8;
    localparam int          CTL_SPEED      = 13;
    // reset, loopback, speed, power-down, isolate, duplex, collision test
    localparam logic [15:0] CTL_CLEAR_MASK = 16'hED80;

    typedef struct packed {
        logic        autoneg;
        logic        speed100;
        logic        full_duplex;
        logic        mii_expected;
        logic [15:0] adv;
    } scan_cfg_t;

    typedef struct packed {
        logic [15:0] value;
        logic        an_toggled;
    } ctl_plan_t;

    typedef enum logic [3:0] {
        S_IDLE, S_PROBE, S_RDCTL, S_RDADV, S_WRADV, S_CTL,
        S_WRC1, S_PAUSE, S_WRC2, S_NEXT, S_FIN
    } seq_state_t;

    function automatic logic phy_present(input logic [15:0] s);
        return ((s & 16'h8301) == 16'h8001) || (!s[15] && (s[14:11] != 4'b0000));
    endfunction

    function automatic logic [15:0] adv_from_status(input logic [15:0] s);
        return ((s >> 6) & 16'h03E0) | 16'h0001;
    endfunction

    function automatic ctl_plan_t plan_ctl(input logic [15:0] cur, input scan_cfg_t cfg);
        ctl_plan_t   p;
        logic [15:0] v;
        v            = cur;
        v[CTL_AN_EN] = cfg.autoneg;
        p.an_toggled = (v != cur);
        if (cfg.autoneg && p.an_toggled)
            v[CTL_AN_RESTART] = 1'b1;
        v             = v & ~CTL_CLEAR_MASK;
        v[CTL_DUPLEX] = cfg.full_duplex;
        v[CTL_SPEED]  = cfg.speed100;
        p.value       = v;
        return p;
    endfunction

endpackage

// File: rtl/phy_scan_pause.sv
module phy_scan_pause #(
    parameter int PAUSE_CYCLES = 2000,
    localparam int PAUSE_W = $clog2(PAUSE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic idle
);
    logic [PAUSE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= PAUSE_W'(PAUSE_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign idle = (cnt_q == '0);
endmodule

// File: rtl/phy_scan_table.sv
module phy_scan_table #(
    parameter int MAX_PHYS = 4,
    localparam int CNT_W = $clog2(MAX_PHYS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  add_en,
    input  logic [4:0]            add_addr,
    input  logic                  fallback,
    output logic [5*MAX_PHYS-1:0] table_flat,
    output logic [CNT_W-1:0]      count,
    output logic                  full
);
    logic [CNT_W-1:0] cnt_q;

    assign full  = (cnt_q == CNT_W'(MAX_PHYS));
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (add_en && !full)
            cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < MAX_PHYS; g++) begin : g_slot
        logic [4:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst || clear)
                slot_q <= '0;
            else if (add_en && !full && cnt_q == CNT_W'(g))
                slot_q <= add_addr;
            else if (fallback && g == 0)
                slot_q <= 5'd1;
        end
        assign table_flat[5*g +: 5] = slot_q;
    end
endmodule

// File: rtl/phy_scan_seq.sv
module phy_scan_seq
    import phy_scan_pkg::*;
#(
    parameter int MAX_PHYS     = 4,
    parameter int PAUSE_CYCLES = 2000,
    localparam int CNT_W = $clog2(MAX_PHYS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  cfg_autoneg,
    input  logic                  cfg_speed100,
    input  logic                  cfg_full_duplex,
    input  logic                  cfg_mii_expected,
    input  logic [15:0]           cfg_adv,
    output logic                  req_valid,
    output logic                  req_write,
    output logic [4:0]            req_phy,
    output logic [4:0]            req_reg,
    output logic [15:0]           req_wdata,
    input  logic                  mdio_done,
    input  logic [15:0]           mdio_rdata,
    output logic [5*MAX_PHYS-1:0] phy_table,
    output logic [CNT_W-1:0]      phy_count,
    output logic                  scan_done
);
    localparam logic [5:0] LAST_IDX = 6'd32;

    seq_state_t  state_q;
    logic [5:0]  idx_q;
    logic [15:0] stat_q;
    logic [15:0] ctrl_q;
    logic [15:0] adv_to_q;
    scan_cfg_t   cfg_q;
    logic        done_q;

    ctl_plan_t   plan;
    logic [15:0] adv_seen;
    logic [15:0] adv_want;
    logic        add_en;
    logic        fallback;
    logic        pause_load;
    logic        pause_idle;
    logic        tab_full;

    assign plan     = plan_ctl(ctrl_q, cfg_q);
    assign adv_seen = (mdio_rdata[8:5] == 4'b0000) ? adv_from_status(stat_q) : mdio_rdata;
    assign adv_want = (cfg_q.adv != 16'h0000) ? cfg_q.adv : adv_seen;

    assign add_en     = !start && state_q == S_PROBE && mdio_done && phy_present(mdio_rdata);
    assign fallback   = !start && state_q == S_FIN && phy_count == '0 && cfg_q.mii_expected;
    assign pause_load = !start && state_q == S_WRC1 && mdio_done && plan.an_toggled;

    always_comb begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_reg   = REG_STAT;
        req_wdata = 16'h0000;
        req_phy   = idx_q[4:0];
        unique case (state_q)
            S_PROBE: begin req_valid = 1'b1; req_reg = REG_STAT; end
            S_RDCTL: begin req_valid = 1'b1; req_reg = REG_CTRL; end
            S_RDADV: begin req_valid = 1'b1; req_reg = REG_ADV;  end
            S_WRADV: begin
                req_valid = 1'b1; req_write = 1'b1;
                req_reg   = REG_ADV; req_wdata = adv_to_q;
            end
            S_WRC1, S_WRC2: begin
                req_valid = 1'b1; req_write = 1'b1;
                req_reg   = REG_CTRL; req_wdata = plan.value;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            idx_q    <= 6'd1;
            stat_q   <= '0;
            ctrl_q   <= '0;
            adv_to_q <= '0;
            cfg_q    <= '0;
            done_q   <= 1'b0;
        end else if (start) begin
            state_q <= S_PROBE;
            idx_q   <= 6'd1;
            done_q  <= 1'b0;
            cfg_q   <= '{autoneg: cfg_autoneg, speed100: cfg_speed100,
                         full_duplex: cfg_full_duplex, mii_expected: cfg_mii_expected,
                         adv: cfg_adv};
        end else begin
            unique case (state_q)
                S_PROBE: if (mdio_done) begin
                    stat_q  <= mdio_rdata;
                    state_q <= phy_present(mdio_rdata) ? S_RDCTL : S_NEXT;
                end
                S_RDCTL: if (mdio_done) begin
                    ctrl_q  <= mdio_rdata;
                    state_q <= S_RDADV;
                end
                S_RDADV: if (mdio_done) begin
                    adv_to_q <= adv_want;
                    state_q  <= (adv_want != adv_seen) ? S_WRADV : S_CTL;
                end
                S_WRADV: if (mdio_done) state_q <= S_CTL;
                S_CTL:   state_q <= (plan.value != ctrl_q) ? S_WRC1 : S_NEXT;
                S_WRC1:  if (mdio_done) state_q <= plan.an_toggled ? S_PAUSE : S_NEXT;
                S_PAUSE: if (pause_idle) state_q <= S_WRC2;
                S_WRC2:  if (mdio_done) state_q <= S_NEXT;
                S_NEXT: begin
                    if (tab_full || idx_q == LAST_IDX)
                        state_q <= S_FIN;
                    else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= S_PROBE;
                    end
                end
                S_FIN: begin
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: ;
            endcase
        end
    end

    assign scan_done = done_q;

    phy_scan_pause #(.PAUSE_CYCLES(PAUSE_CYCLES)) pause_i (
        .clk  (clk),
        .rst  (rst || start),
        .load (pause_load),
        .idle (pause_idle)
    );

    phy_scan_table #(.MAX_PHYS(MAX_PHYS)) table_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .add_en     (add_en),
        .add_addr   (idx_q[4:0]),
        .fallback   (fallback),
        .table_flat (phy_table),
        .count      (phy_count),
        .full       (tab_full)
    );
endmodule

// File: rtl/phy_scan_chk.sv
module phy_scan_chk #(
    parameter int MAX_PHYS     = 4,
    parameter int PAUSE_CYCLES = 2000,
    localparam int CNT_W = $clog2(MAX_PHYS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             req_valid,
    input logic             req_write,
    input logic [4:0]       req_phy,
    input logic [4:0]       req_reg,
    input logic [15:0]      req_wdata,
    input logic             mdio_done,
    input logic [CNT_W-1:0] phy_count,
    input logic             scan_done
);
    logic [31:0] gap_q;
    logic        prev_ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q      <= '0;
            prev_ctl_q <= 1'b0;
        end else if (req_valid && mdio_done) begin
            gap_q      <= '0;
            prev_ctl_q <= req_write && req_reg == 5'd0;
        end else if (gap_q != 32'hFFFF_FFFF) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r8_req_stable: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mdio_done && !start) |=>
        (req_valid && $stable(req_phy) && $stable(req_reg) &&
         $stable(req_write) && $stable(req_wdata)));

    a_r8_idle_when_done: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> !req_valid);

    a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (!scan_done && phy_count == '0));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        phy_count <= CNT_W'(MAX_PHYS));

    a_r6_pause_gap: assert property (@(posedge clk) disable iff (rst || start)
        ($rose(req_valid) && req_write && req_reg == 5'd0 && prev_ctl_q) |->
        (gap_q >= 32'(PAUSE_CYCLES)));
endmodule

bind phy_scan_seq phy_scan_chk #(.MAX_PHYS(MAX_PHYS), .PAUSE_CYCLES(PAUSE_CYCLES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .mdio_done (mdio_done),
    .phy_count (phy_count),
    .scan_done (scan_done)
);

// File: tb/phy_scan_seq_tb_top.sv
module phy_scan_seq_tb_top;
    localparam int MAXP  = 4;
    localparam int PAUSE = 40;
    localparam int CW    = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic           start = 1'b0;
    logic           cfg_autoneg = 1'b0, cfg_speed100 = 1'b0, cfg_full_duplex = 1'b0;
    logic           cfg_mii_expected = 1'b0;
    logic [15:0]    cfg_adv = '0;
    logic           req_valid, req_write;
    logic [4:0]     req_phy, req_reg;
    logic [15:0]    req_wdata;
    logic           mdio_done = 1'b0;
    logic [15:0]    mdio_rdata = '0;
    logic [5*MAXP-1:0] phy_table;
    logic [CW-1:0]  phy_count;
    logic           scan_done;

    phy_scan_seq #(.MAX_PHYS(MAXP), .PAUSE_CYCLES(PAUSE)) dut_i (.*);

    int errors = 0;
    int checks = 0;

    // PHY register model and access log
    logic [15:0] m_stat [32];
    logic [15:0] m_ctl  [32];
    logic [15:0] m_adv  [32];
    logic        m_busy = 1'b0;
    int          m_wait = 0;
    logic        m_wr;
    logic [4:0]  m_phy, m_reg;
    logic [15:0] m_wd;
    int          cyc = 0;
    int          lat_cyc = 0;
    int          act_n = 0;
    logic [26:0] act_e [256];
    int          act_lat [256];
    int          act_don [256];
    int          stab_viol = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mdio_done) begin
            mdio_done <= 1'b0;
        end else if (m_busy) begin
            if (req_valid && (req_write != m_wr || req_phy != m_phy ||
                              req_reg != m_reg || req_wdata != m_wd))
                stab_viol++;
            if (m_wait == 0) begin
                mdio_done <= 1'b1;
                m_busy    <= 1'b0;
                if (m_wr) begin
                    if (m_reg == 5'd0) m_ctl[m_phy] = m_wd;
                    if (m_reg == 5'd4) m_adv[m_phy] = m_wd;
                    mdio_rdata <= 16'h0000;
                end else begin
                    mdio_rdata <= (m_reg == 5'd1) ? m_stat[m_phy] :
                                  (m_reg == 5'd0) ? m_ctl[m_phy]  :
                                  (m_reg == 5'd4) ? m_adv[m_phy]  : 16'hFFFF;
                end
                if (act_n < 256) begin
                    act_e[act_n]   = {m_wr, m_phy, m_reg, m_wr ? m_wd : 16'h0000};
                    act_lat[act_n] = lat_cyc;
                    act_don[act_n] = cyc;
                    act_n++;
                end
            end else begin
                m_wait <= m_wait - 1;
            end
        end else if (req_valid && !rst) begin
            m_busy  <= 1'b1;
            m_wait  <= 1;
            m_wr    <= req_write;
            m_phy   <= req_phy;
            m_reg   <= req_reg;
            m_wd    <= req_wdata;
            lat_cyc = cyc;
        end
    end

    // expected results
    int          exp_n;
    logic [26:0] exp_e [256];
    logic [4:0]  exp_tab [MAXP];
    int          exp_cnt;

    function automatic logic present_b(input logic [15:0] s);
        return (s[15] & ~s[9] & ~s[8] & s[0]) | (~s[15] & (|s[14:11]));
    endfunction

    task automatic push(input logic w, input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
        exp_e[exp_n] = {w, a, r, d};
        exp_n++;
    endtask

    task automatic build_exp(input logic an, input logic sp, input logic fd,
                             input logic me, input logic [15:0] cadv);
        exp_n = 0;
        exp_cnt = 0;
        for (int k = 0; k < MAXP; k++) exp_tab[k] = 5'd0;
        for (int i = 1; i <= 32; i++) begin
            logic [4:0]  a;
            logic [15:0] s, c, seen, want, nb;
            logic        tog;
            if (exp_cnt == MAXP) break;
            a = 5'(i % 32);
            push(1'b0, a, 5'd1, 16'h0);
            s = m_stat[a];
            if (present_b(s)) begin
                exp_tab[exp_cnt] = a;
                exp_cnt++;
                push(1'b0, a, 5'd0, 16'h0);
                push(1'b0, a, 5'd4, 16'h0);
                seen = ((m_adv[a] & 16'h01E0) == 16'h0) ? {6'd0, s[15:11], 4'd0, 1'b1} : m_adv[a];
                want = (cadv == 16'h0) ? seen : cadv;
                if (want != seen) push(1'b1, a, 5'd4, want);
                c   = m_ctl[a];
                nb  = an ? (c | 16'h1000) : (c & 16'hEFFF);
                tog = (nb != c);
                if (an && tog) nb = nb | 16'h0200;
                nb = (nb & 16'h127F) | (fd ? 16'h0100 : 16'h0) | (sp ? 16'h2000 : 16'h0);
                if (nb != c) begin
                    push(1'b1, a, 5'd0, nb);
                    if (tog) push(1'b1, a, 5'd0, nb);
                end
            end
        end
        if (exp_cnt == 0 && me) exp_tab[0] = 5'd1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic run_scan(input logic an, input logic sp, input logic fd,
                            input logic me, input logic [15:0] cadv);
        int first_bad;
        build_exp(an, sp, fd, me, cadv);
        @(negedge clk);
        cfg_autoneg = an; cfg_speed100 = sp; cfg_full_duplex = fd;
        cfg_mii_expected = me; cfg_adv = cadv;
        act_n = 0;
        stab_viol = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!scan_done && phy_count == '0 && phy_table == '0, "R9", "cleared after start",
              {scan_done, 4'(phy_count)}, 0);
        while (!scan_done) @(negedge clk);
        check(act_n == exp_n, "R1/R3", "access count", act_n, exp_n);
        first_bad = -1;
        for (int i = 0; i < exp_n && i < act_n; i++)
            if (first_bad < 0 && act_e[i] != exp_e[i]) first_bad = i;
        check(first_bad < 0, "R2/R4/R5", "access sequence",
              first_bad < 0 ? 0 : act_e[first_bad], first_bad < 0 ? 0 : exp_e[first_bad]);
        check(phy_count == CW'(exp_cnt), "R3", "phy count", phy_count, exp_cnt);
        for (int k = 0; k < MAXP; k++)
            if (k < exp_cnt || k == 0)
                check(phy_table[5*k +: 5] == exp_tab[k], (exp_cnt == 0) ? "R7" : "R1",
                      "table slot", phy_table[5*k +: 5], exp_tab[k]);
        for (int i = 1; i < act_n; i++)
            if (act_e[i][26] && act_e[i-1][26] && act_e[i][20:16] == 5'd0 &&
                act_e[i-1][20:16] == 5'd0 && act_e[i][25:21] == act_e[i-1][25:21])
                check(act_lat[i] - act_don[i-1] >= PAUSE, "R6", "pause between control writes",
                      act_lat[i] - act_don[i-1], PAUSE);
        check(stab_viol == 0, "R8", "request stable while pending", stab_viol, 0);
    endtask

    task automatic clear_bus();
        for (int a = 0; a < 32; a++) begin
            m_stat[a] = 16'hFFFF;
            m_ctl[a]  = 16'hFFFF;
            m_adv[a]  = 16'hFFFF;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        clear_bus();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!scan_done && phy_count == '0 && !req_valid && phy_table == '0,
              "R9", "reset state", {scan_done, req_valid}, 0);

        // empty bus, PHY expected: address 1 fallback
        run_scan(1'b1, 1'b0, 1'b0, 1'b1, 16'h0);
        // empty bus, nothing expected (R7)
        run_scan(1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

        // presence boundaries (R2), address 0 last (R1), AN turned on (R6)
        clear_bus();
        m_stat[2] = 16'h8001; m_ctl[2] = 16'h1000; m_adv[2] = 16'h01E1;
        m_stat[3] = 16'h8101;
        m_stat[4] = 16'h0800; m_ctl[4] = 16'h3100; m_adv[4] = 16'h0001;
        m_stat[5] = 16'h8800;
        m_stat[6] = 16'h0000;
        m_stat[0] = 16'h7849; m_ctl[0] = 16'h0000; m_adv[0] = 16'h0061;
        run_scan(1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

        // more PHYs than slots: early stop (R3), configured advertisement (R4)
        clear_bus();
        foreach (m_stat[a]) if (a == 3 || a == 7 || a == 9 || a == 20 || a == 25 || a == 0) begin
            m_stat[a] = 16'h7809; m_ctl[a] = 16'h1200; m_adv[a] = 16'h05E1;
        end
        run_scan(1'b1, 1'b0, 1'b0, 1'b1, 16'h01E1);

        // forced mode turning AN off (R5, R6)
        clear_bus();
        m_stat[31] = 16'h7849; m_ctl[31] = 16'h1000; m_adv[31] = 16'h01E1;
        m_stat[1]  = 16'h7849; m_ctl[1]  = 16'h2100; m_adv[1]  = 16'h0000;
        run_scan(1'b0, 1'b1, 1'b1, 1'b0, 16'h0);

        // random scans
        for (int n = 0; n < 14; n++) begin
            for (int a = 0; a < 32; a++) begin
                int r;
                r = $urandom % 4;
                m_stat[a] = (r < 2) ? 16'hFFFF : (r == 2) ? (16'h7809 | 16'($urandom & 32'h0006))
                                                          : 16'($urandom);
                m_ctl[a]  = 16'($urandom);
                m_adv[a]  = ($urandom % 2) ? 16'($urandom) : 16'($urandom & 32'hFE1F);
            end
            run_scan(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     ($urandom % 2) ? 16'h0 : 16'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule